// File: doc/BRIEF.md
# Associative Key-Value Cache Store

This block is a small fully associative store of key/value pairs. A requester issues one command per clock through a request bundle: a valid strobe, a read/write selector, a key and a write value. A lookup compares the key against every occupied slot at once. When an occupied slot holds that key, the block returns the slot's value and raises the hit flag on the following cycle.

A write follows a three-tier placement rule. If the key is already present, the value in that slot is replaced. Otherwise the pair goes into the lowest-numbered empty slot. When no slot is empty, a round-robin victim pointer picks the slot to overwrite, and the pointer then moves on by one. A synchronous reset empties every slot and points the victim pointer back at slot 0.

Top module: `kvAssocStore`

## Requirements
- R1: While reset is high, and on the first cycle after it, rspHit is 0 and rspValue is 0. After reset the victim pointer selects slot 0, so the ninth new key written after a reset replaces the first key written after it.
- R2: A lookup (cmdIsPut = 0) whose key is held by an occupied slot gives rspHit = 1 and that slot's value on rspValue one cycle after the command is accepted.
- R3: A lookup whose key is held by no occupied slot gives rspHit = 0 one cycle later. rspValue is then unspecified.
- R4: A write (cmdIsPut = 1) whose key is already held replaces that slot's value and takes no further slot. The victim pointer does not move.
- R5: A write of a new key while empty slots exist fills the lowest-numbered empty slot and leaves the victim pointer unchanged.
- R6: A write of a new key while all slots are occupied overwrites the slot under the victim pointer, which then advances by one and wraps from the last slot to slot 0. The evicted key no longer hits.
- R7: Every accepted write gives rspHit = 1 and echoes the written value on rspValue one cycle later.
- R8: While cmdValid is low, the stored contents and the victim pointer do not change, rspHit is 0 on the next cycle, and rspValue keeps its previous value.
- R9: Only occupied slots take part in a match. Keys that were stored before a reset never hit afterwards, and at most one occupied slot holds any given key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command accepted on this edge when high |
| cmdIsPut | input | 1 | 0 = lookup, 1 = write |
| cmdKey | input | KEY_W (8) | Key to look up or store |
| cmdValue | input | VAL_W (16) | Value to store on a write |
| rspValue | output | VAL_W (16) | Value found by a lookup, or the echoed write value |
| rspHit | output | 1 | Key found (lookup) or stored (write) |

## Verification
The hardest path to reach from the ports is eviction. It happens only after every slot is occupied. It then has to be shown that in-place updates and idle cycles leave the victim pointer where it was, and that the pointer wraps past the last slot. The stimulus fills all eight slots, mixes updates and idle cycles with runs of new keys long enough to wrap the pointer, and probes evicted and surviving keys with lookups. It then resets in the middle of the run and repeats the fill to show that the pointer restarts at slot 0 and that keys from before the reset no longer hit.

// File: rtl/kvPkg.sv
package kvPkg;

  // Strobes issued by the control to the datapath for one accepted command.
  typedef struct packed {
    logic wrEn;      // write key/value into slot wrIdx and mark it occupied
    logic loadRead;  // capture the matched value into the response register
    logic loadEcho;  // capture the written value into the response register
  } kvCtl_t;

endpackage

// File: rtl/kvDatapath.sv
module kvDatapath
  import kvPkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int KEY_W     = 8,
  parameter int VAL_W     = 16,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  kvCtl_t               ctl,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [KEY_W-1:0]     key,
  input  logic [VAL_W-1:0]     valueIn,
  output logic [NUM_SLOTS-1:0] matchVec,
  output logic [NUM_SLOTS-1:0] validVec,
  output logic [VAL_W-1:0]     valueOut
);

  logic [KEY_W-1:0] keyQ [NUM_SLOTS];
  logic [VAL_W-1:0] valQ [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] validQ;
  logic [VAL_W-1:0] readVal;
  logic [VAL_W-1:0] valueOutQ;

  // Per-slot storage and comparator.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    logic slotSel;
    assign slotSel = ctl.wrEn && (wrIdx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ[s] <= 1'b0;
      end else if (slotSel) begin
        validQ[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        keyQ[s] <= '0;
        valQ[s] <= '0;
      end else if (slotSel) begin
        keyQ[s] <= key;
        valQ[s] <= valueIn;
      end
    end

    assign matchVec[s] = validQ[s] && (keyQ[s] == key);
  end

  assign validVec = validQ;

  // AND-OR read mux; at most one match is ever set.
  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      readVal = readVal | (matchVec[i] ? valQ[i] : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valueOutQ <= '0;
    end else if (ctl.loadRead) begin
      valueOutQ <= readVal;
    end else if (ctl.loadEcho) begin
      valueOutQ <= valueIn;
    end
  end

  assign valueOut = valueOutQ;

  AST_UNIQUE_KEY: assert property (@(posedge clk) disable iff (rst)
    $onehot0(matchVec)) else $error("duplicate key held"); // R9

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.wrEn |=> $stable(validQ)) else $error("occupancy changed without write"); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ctl.loadRead || ctl.loadEcho) |=> $stable(valueOutQ)) else $error("response moved while idle"); // R8

  AST_ECHO: assert property (@(posedge clk) disable iff (rst)
    ctl.loadEcho && !ctl.loadRead |=> valueOutQ == $past(valueIn)) else $error("write echo wrong"); // R7

endmodule

// File: rtl/kvControl.sv
module kvControl
  import kvPkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic                 cmdIsPut,
  input  logic [NUM_SLOTS-1:0] matchVec,
  input  logic [NUM_SLOTS-1:0] validVec,
  output kvCtl_t               ctl,
  output logic [IDX_W-1:0]     wrIdx,
  output logic                 hit
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] freeIdx;
  logic anyMatch;
  logic storeFull;
  logic isGet;
  logic isPut;
  logic evict;
  logic hitQ;

  assign isGet = cmdValid && !cmdIsPut;
  assign isPut = cmdValid && cmdIsPut;

  // Encode the single matching slot.
  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (matchVec[i]) matchIdx = IDX_W'(i);
    end
  end
  assign anyMatch = |matchVec;

  // Lowest-numbered empty slot: scan downward so the lowest index wins.
  always_comb begin
    freeIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end
  assign storeFull = &validVec;

  // Three-tier placement: in place, then first empty, then victim.
  always_comb begin
    if (anyMatch)        wrIdx = matchIdx;
    else if (!storeFull) wrIdx = freeIdx;
    else                 wrIdx = rrPtr;
  end

  assign evict = isPut && !anyMatch && storeFull;

  always_comb begin
    ctl          = '0;
    ctl.wrEn     = isPut;
    ctl.loadRead = isGet;
    ctl.loadEcho = isPut;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr <= '0;
    end else if (evict) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hitQ <= 1'b0;
    end else begin
      hitQ <= isPut || (isGet && anyMatch);
    end
  end

  assign hit = hitQ;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    evict |=> rrPtr == (($past(rrPtr) == LAST_IDX) ? '0 : $past(rrPtr) + 1'b1))
    else $error("victim pointer step wrong"); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !evict |=> $stable(rrPtr)) else $error("victim pointer moved without eviction"); // R4

  AST_EVICT_FULL: assert property (@(posedge clk) disable iff (rst)
    evict |-> $countones(validVec) == NUM_SLOTS) else $error("eviction with a free slot"); // R6

  AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    isPut && !anyMatch && !storeFull |-> !validVec[wrIdx]) else $error("fill hit an occupied slot"); // R5

  AST_PUT_HIT: assert property (@(posedge clk) disable iff (rst)
    isPut |=> hit) else $error("write did not report hit"); // R7

  AST_IDLE_NOHIT: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |=> !hit) else $error("hit while idle"); // R8

  AST_MISS_NOHIT: assert property (@(posedge clk) disable iff (rst)
    isGet && !anyMatch |=> !hit) else $error("lookup miss reported hit"); // R3

endmodule

// File: rtl/kvAssocStore.sv
module kvAssocStore
  import kvPkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int KEY_W     = 8,
  parameter int VAL_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdValid,
  input  logic             cmdIsPut,
  input  logic [KEY_W-1:0] cmdKey,
  input  logic [VAL_W-1:0] cmdValue,
  output logic [VAL_W-1:0] rspValue,
  output logic             rspHit
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  kvCtl_t               ctl;
  logic [IDX_W-1:0]     wrIdx;
  logic [NUM_SLOTS-1:0] matchVec;
  logic [NUM_SLOTS-1:0] validVec;

  kvControl #(
    .NUM_SLOTS(NUM_SLOTS),
    .IDX_W    (IDX_W)
  ) uControl (
    .clk     (clk),
    .rst     (rst),
    .cmdValid(cmdValid),
    .cmdIsPut(cmdIsPut),
    .matchVec(matchVec),
    .validVec(validVec),
    .ctl     (ctl),
    .wrIdx   (wrIdx),
    .hit     (rspHit)
  );

  kvDatapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .KEY_W    (KEY_W),
    .VAL_W    (VAL_W),
    .IDX_W    (IDX_W)
  ) uDatapath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .wrIdx   (wrIdx),
    .key     (cmdKey),
    .valueIn (cmdValue),
    .matchVec(matchVec),
    .validVec(validVec),
    .valueOut(rspValue)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !rspHit && rspValue == '0) else $error("reset did not clear response"); // R1

endmodule

// File: tb/tb_kvAssocStore.sv
module tb_kvAssocStore;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic        cmdIsPut = 1'b0;
  logic [7:0]  cmdKey = '0;
  logic [15:0] cmdValue = '0;
  logic [15:0] rspValue;
  logic        rspHit;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  kvAssocStore dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdIsPut(cmdIsPut),
    .cmdKey(cmdKey), .cmdValue(cmdValue), .rspValue(rspValue), .rspHit(rspHit)
  );

  typedef struct {
    logic        hit;
    logic [15:0] val;
    bit          chkVal;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  // Reference model built from the requirements.
  logic [7:0]  mKey [8];
  logic [15:0] mVal [8];
  bit          mValid [8];
  int          mPtr;
  logic [15:0] mLast;
  bit          mLastKnown;

  function automatic void modelClear();
    for (int i = 0; i < 8; i++) mValid[i] = 0;
    mPtr = 0;
    mLast = '0;
    mLastKnown = 1;
  endfunction

  task automatic doCmd(bit en, bit put, logic [7:0] k, logic [15:0] v, string tag);
    exp_t e;
    int m;
    int f;
    @(negedge clk);
    cmdValid = en; cmdIsPut = put; cmdKey = k; cmdValue = v;
    m = -1;
    f = -1;
    for (int i = 0; i < 8; i++) if (mValid[i] && mKey[i] == k) m = i;
    for (int i = 7; i >= 0; i--) if (!mValid[i]) f = i;
    e.tag = tag;
    if (!en) begin
      e.hit = 0; e.val = mLast; e.chkVal = mLastKnown;
    end else if (put) begin
      if (m >= 0) mVal[m] = v;
      else if (f >= 0) begin mValid[f] = 1; mKey[f] = k; mVal[f] = v; end
      else begin mKey[mPtr] = k; mVal[mPtr] = v; mPtr = (mPtr + 1) % 8; end
      e.hit = 1; e.val = v; e.chkVal = 1;
      mLast = v; mLastKnown = 1;
    end else if (m >= 0) begin
      e.hit = 1; e.val = mVal[m]; e.chkVal = 1;
      mLast = mVal[m]; mLastKnown = 1;
    end else begin
      e.hit = 0; e.val = '0; e.chkVal = 0;
      mLastKnown = 0;
    end
    expQ.push_back(e);
  endtask

  task automatic finishCmds();
    @(negedge clk);
    cmdValid = 0;
    wait (expQ.size() == 0);
  endtask

  task automatic doReset();
    finishCmds();
    @(negedge clk);
    rst = 1; cmdValid = 0;
    @(negedge clk);
    testsRun++;
    if (rspHit !== 1'b0 || rspValue !== 16'h0) begin
      testsFailed++;
      $display("FAIL R1 reset state: hit=%0b value=%h expected hit=0 value=0000", rspHit, rspValue);
    end
    rst = 0;
    modelClear();
  endtask

  // Monitor: each command's response is sampled 1 ns after its capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        testsRun++;
        if (rspHit !== e.hit || (e.chkVal && rspValue !== e.val)) begin
          testsFailed++;
          $display("FAIL %s: hit=%0b value=%h expected hit=%0b value=%h", e.tag,
                   rspHit, rspValue, e.hit, e.val);
        end
      end
    end
  end

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    doReset();

    // R3 / R9: empty store misses.
    doCmd(1, 0, 8'h10, 16'h0, "R9 lookup on empty store");
    doCmd(1, 0, 8'h00, 16'h0, "R3 lookup miss key 00");

    // R5 / R7: fill eight slots.
    for (int i = 0; i < 8; i++)
      doCmd(1, 1, 8'h20 + 8'(i), 16'hA000 + 16'(i), "R7 fill write reports hit");
    for (int i = 0; i < 8; i++)
      doCmd(1, 0, 8'h20 + 8'(i), 16'h0, "R2 lookup after fill");

    // R4: in-place update consumes no slot.
    doCmd(1, 1, 8'h23, 16'hBEEF, "R4 update in place");
    doCmd(1, 0, 8'h23, 16'h0, "R4 updated value read back");

    // R8: idle cycles with write-looking inputs change nothing.
    doCmd(0, 1, 8'h99, 16'h1234, "R8 idle no hit, value held");
    doCmd(0, 1, 8'h23, 16'h5555, "R8 idle no hit, value held");
    doCmd(1, 0, 8'h99, 16'h0, "R8 idle write ignored");
    doCmd(1, 0, 8'h23, 16'h0, "R8 value unchanged by idle");

    // R6: full store evicts slot 0 first, then 1.
    doCmd(1, 1, 8'h40, 16'hC000, "R6 evict first victim");
    doCmd(1, 0, 8'h20, 16'h0, "R6 evicted key misses");
    doCmd(1, 0, 8'h21, 16'h0, "R6 surviving key hits");
    doCmd(1, 1, 8'h21, 16'hC111, "R4 update does not advance pointer");
    doCmd(1, 1, 8'h41, 16'hC001, "R6 evict second victim");
    doCmd(1, 0, 8'h21, 16'h0, "R6 second victim gone");
    doCmd(1, 0, 8'h22, 16'h0, "R6 third slot intact");
    // Run past the end to wrap the pointer.
    for (int i = 2; i < 10; i++)
      doCmd(1, 1, 8'h40 + 8'(i), 16'hC000 + 16'(i), "R6 eviction run wraps");
    for (int i = 0; i < 10; i++)
      doCmd(1, 0, 8'h40 + 8'(i), 16'h0, "R6 lookup after wrap");
    doCmd(1, 0, 8'h23, 16'h0, "R6 old key evicted by wrap");

    // R1 / R9: reset empties everything and restarts pointer.
    doReset();
    doCmd(1, 0, 8'h49, 16'h0, "R9 stale key after reset");
    doCmd(1, 0, 8'h00, 16'h0, "R9 zero key after reset");
    for (int i = 0; i < 8; i++)
      doCmd(1, 1, 8'h60 + 8'(i), 16'hD000 + 16'(i), "R5 refill after reset");
    doCmd(1, 1, 8'h70, 16'hE000, "R1 pointer restarts at slot 0");
    doCmd(1, 0, 8'h60, 16'h0, "R1 first refill key evicted");
    doCmd(1, 0, 8'h61, 16'h0, "R1 second refill key kept");
    doCmd(1, 0, 8'h70, 16'h0, "R2 new key found");

    finishCmds();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule